// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a memory-mapped watchdog for a system controller. Software reaches it over a simple single-cycle register bus made of write enable, address, write data and combinational read data. Three registers are decoded:

- a control register used only to restart the countdown;
- a configuration register that selects what happens on expiry;
- a mode register that holds the enable bit and a 4-bit interval code.

A prescaler divides the input clock into half-second ticks. A down-counter counts those ticks over the selected interval.

Once enabled, the countdown is restarted only by writing one exact keyed word to the control register. Any other control write leaves the countdown alone. When the interval runs out, the block acts according to the configuration field:

- it drives a system-reset pulse of fixed length;
- or it raises a level interrupt;
- or it does nothing.

After expiry the interval reloads and the countdown runs again until it is restarted or disabled.

Top module: `keyed_watchdog`

## Requirements
- R1: After synchronous reset (`rst_n` low at a clock edge), both outputs are low, the watchdog is disabled and every register reads 0.
- R2: Registers are decoded at 0x10 (control), 0x14 (configuration) and 0x18 (mode). Configuration reads back its action field in bits 1:0. Mode reads back its enable bit in bit 0 and its interval code in bits 7:4. All other bits read 0, and control always reads 0.
- R3: With `HALF_SEC_CYCLES` clock cycles per tick, the interval code sets the tick count. Code 0 gives 1 tick (0.5 s). Codes 1 to 6 give 2×code ticks. Codes 7 to 11 give 16, 20, 24, 28 and 32 ticks. The output action appears exactly ticks×`HALF_SEC_CYCLES` clock edges after the enabling write edge.
- R4: Interval codes 12 to 15 behave as code 11 (32 ticks).
- R5: While the watchdog is enabled, a control write whose full 32-bit word is 0x000014AF restarts the countdown from the full interval of the stored code. In that word bit 0 is 1 and bits 12:1 hold the key 0xA57.
- R6: A control write with any other value is ignored: the pending expiry keeps its original time. This covers bit 0 clear, a wrong key, and any upper bit set.
- R7: Writing the mode register with bit 0 set while the watchdog already runs does not disturb the countdown. A new code stored by that write is used from the next reload.
- R8: Writing the mode register with bit 0 clear stops the watchdog. No expiry follows, and an expiry due at that same edge is suppressed.
- R9: With action 01, expiry drives `wd_reset_o` high from the expiry edge for exactly `RST_PULSE_CYCLES` clock cycles.
- R10: With action 10, expiry sets `wd_irq_o`. It stays high until a valid restart or a stop write, which clear it at that write's edge.
- R11: With action 00 or 11, expiry drives neither output.
- R12: After an expiry the countdown reloads and expires again one full interval later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| wd_reset_o | output | 1 | System-reset pulse on expiry (action 01) |
| wd_irq_o | output | 1 | Interrupt level on expiry (action 10) |

## Verification
A write takes effect at the clock edge that samples it. The output action for an interval of N ticks appears after edge N×`HALF_SEC_CYCLES` counted from that write edge. The reset pulse falls `RST_PULSE_CYCLES` edges after it rises, and an interrupt clears at the restart or stop edge itself.

Every bench task starts and ends at a falling clock edge and counts falling edges from the write. Each output is therefore checked one cycle before and exactly at the edge where it must change. Read data is combinational and is sampled shortly after the address settles, with no clock between.

// File: rtl/wdt_pkg.sv
// Package: shared constants, the expiry action encoding and the
// interval-code to tick-count mapping for the keyed watchdog.
// Assumes byte addresses and a half-second tick base.
package wdt_pkg;

    localparam int TICK_W = 6;

    localparam logic [7:0] OFS_CTRL = 8'h10;
    localparam logic [7:0] OFS_CFG  = 8'h14;
    localparam logic [7:0] OFS_MODE = 8'h18;

    // Exact word that restarts the countdown (bit 0 = 1, key 0xA57 in 12:1).
    localparam logic [31:0] RESTART_WORD = 32'h0000_14AF;

    typedef enum logic [1:0] {
        ACT_NONE  = 2'b00,
        ACT_RESET = 2'b01,
        ACT_IRQ   = 2'b10,
        ACT_IDLE  = 2'b11
    } wdt_action_e;

    // Number of half-second ticks for an interval code (R3, R4).
    function automatic logic [TICK_W-1:0] code_to_ticks(input logic [3:0] code);
        logic [TICK_W-1:0] c;
        c = TICK_W'(code);
        if (code == 4'd0)       return TICK_W'(1);
        else if (code <= 4'd6)  return TICK_W'(c << 1);
        else if (code <= 4'd11) return TICK_W'((c << 2) - TICK_W'(12));
        else                    return TICK_W'(32);
    endfunction

endpackage

// File: rtl/wdt_regs.sv
// Register file: decodes the three registers and produces the start,
// stop and keyed-restart strobes.
// Assumes single-cycle writes and combinational reads.
module wdt_regs #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              en_q,
    output logic [3:0]        code_q,
    output logic [1:0]        act_q,
    output logic              start_w,
    output logic              stop_w,
    output logic              restart_w,
    output logic [3:0]        load_code
);
    import wdt_pkg::*;

    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(OFS_CFG);
    localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(OFS_MODE);
    localparam logic [DATA_W-1:0] KEYED  = DATA_W'(RESTART_WORD);

    logic wr_ctrl, wr_cfg, wr_mode;

    // Address decode of the current write.
    always_comb begin
        wr_ctrl = bus_we && (bus_addr == A_CTRL);
        wr_cfg  = bus_we && (bus_addr == A_CFG);
        wr_mode = bus_we && (bus_addr == A_MODE);
    end

    // Control strobes: start on an enabling write, stop on a disabling one,
    // restart on the exact keyed word while enabled (R5, R6, R7, R8).
    always_comb begin
        start_w   = wr_mode && bus_wdata[0] && !en_q;
        stop_w    = wr_mode && !bus_wdata[0];
        restart_w = wr_ctrl && (bus_wdata == KEYED) && en_q;
        load_code = start_w ? bus_wdata[7:4] : code_q;
    end

    // Stored register fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            code_q <= 4'd0;
            act_q  <= 2'b00;
        end else begin
            if (wr_cfg)  act_q <= bus_wdata[1:0];
            if (wr_mode) begin
                en_q   <= bus_wdata[0];
                code_q <= bus_wdata[7:4];
            end
        end
    end

    // Read-back mux; control reads as zero (R2).
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_CFG) begin
            bus_rdata[1:0] = act_q;
        end else if (bus_addr == A_MODE) begin
            bus_rdata[0]   = en_q;
            bus_rdata[7:4] = code_q;
        end
    end

endmodule

// File: rtl/wdt_prescaler.sv
// Prescaler: emits one tick every HALF_SEC_CYCLES clocks while running.
// A clear or a stopped state restarts the phase from zero.
module wdt_prescaler #(
    parameter int HALF_SEC_CYCLES = 62_500_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clear,
    output logic tick
);
    localparam int PRE_W = (HALF_SEC_CYCLES > 1) ? $clog2(HALF_SEC_CYCLES) : 1;
    localparam logic [PRE_W-1:0] LAST = PRE_W'(HALF_SEC_CYCLES - 1);

    logic [PRE_W-1:0] pre_q;

    // Tick on the final cycle of each half-second period.
    always_comb tick = run && (pre_q == LAST);

    // Phase counter.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || clear) pre_q <= '0;
        else if (tick)               pre_q <= '0;
        else                         pre_q <= pre_q + 1'b1;
    end

endmodule

// File: rtl/wdt_countdown.sv
// Countdown: counts interval ticks down, strobes expire on the last one
// and reloads for the next period (R3, R12).
// A load has priority over expiry.
module wdt_countdown #(
    parameter int TICK_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              load,
    input  logic [TICK_W-1:0] load_ticks,
    input  logic              tick,
    output logic              expire
);
    logic [TICK_W-1:0] cnt_q;

    // Expiry strobe on the tick that ends the interval.
    always_comb expire = run && tick && !load && (cnt_q == TICK_W'(1));

    // Tick counter with reload on restart or on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt_q <= '0;
        else if (load)  cnt_q <= load_ticks;
        else if (!run)  cnt_q <= '0;
        else if (tick)  cnt_q <= (cnt_q == TICK_W'(1)) ? load_ticks : cnt_q - 1'b1;
    end

endmodule

// File: rtl/wdt_action.sv
// Expiry action: a fixed-length reset pulse or a level interrupt,
// chosen by the configuration field sampled at expiry (R9, R10, R11).
module wdt_action #(
    parameter int RST_PULSE_CYCLES = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] act,
    input  logic       expire,
    input  logic       clear_irq,
    output logic       reset_o,
    output logic       irq_o
);
    import wdt_pkg::*;

    localparam int PW = $clog2(RST_PULSE_CYCLES + 1);

    logic [PW-1:0] pulse_q;

    // Reset pulse length counter.
    always_ff @(posedge clk) begin
        if (!rst_n)                               pulse_q <= '0;
        else if (expire && act == ACT_RESET)      pulse_q <= PW'(RST_PULSE_CYCLES);
        else if (pulse_q != '0)                   pulse_q <= pulse_q - 1'b1;
    end

    // Interrupt level; a clear wins over a simultaneous set.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_irq)                  irq_o <= 1'b0;
        else if (expire && act == ACT_IRQ)        irq_o <= 1'b1;
    end

    // Drive the reset output.
    always_comb reset_o = (pulse_q != '0);

endmodule

// File: rtl/keyed_watchdog.sv
// Top: keyed watchdog timer. Wires the register file, prescaler,
// countdown and expiry action.
// Assumes one clock domain and a synchronous active-low reset.
module keyed_watchdog #(
    parameter int ADDR_W           = 8,
    parameter int DATA_W           = 32,
    parameter int HALF_SEC_CYCLES  = 62_500_000,
    parameter int RST_PULSE_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              wd_reset_o,
    output logic              wd_irq_o
);
    import wdt_pkg::*;

    logic                en_q, start_w, stop_w, restart_w;
    logic [3:0]          code_q, load_code;
    logic [1:0]          act_q;
    logic                run, load, tick, expire;
    logic [TICK_W-1:0]   load_ticks;

    // Run state, load strobe and the interval of the code being loaded.
    always_comb begin
        run        = en_q && !stop_w;
        load       = start_w || restart_w;
        load_ticks = code_to_ticks(load_code);
    end

    wdt_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .en_q(en_q),
        .code_q(code_q), .act_q(act_q), .start_w(start_w), .stop_w(stop_w),
        .restart_w(restart_w), .load_code(load_code)
    );

    wdt_prescaler #(.HALF_SEC_CYCLES(HALF_SEC_CYCLES)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(run), .clear(load), .tick(tick)
    );

    wdt_countdown #(.TICK_W(TICK_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .run(run), .load(load),
        .load_ticks(load_ticks), .tick(tick), .expire(expire)
    );

    wdt_action #(.RST_PULSE_CYCLES(RST_PULSE_CYCLES)) u_act (
        .clk(clk), .rst_n(rst_n), .act(act_q), .expire(expire),
        .clear_irq(restart_w || stop_w), .reset_o(wd_reset_o), .irq_o(wd_irq_o)
    );

endmodule

// File: rtl/wdt_checker.sv
// Checker: temporal properties of the keyed watchdog, bound to the top.
module wdt_checker #(
    parameter int ADDR_W           = 8,
    parameter int DATA_W           = 32,
    parameter int RST_PULSE_CYCLES = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              wd_reset_o,
    input logic              wd_irq_o,
    input logic              en_q,
    input logic [1:0]        act_q,
    input logic              expire
);
    import wdt_pkg::*;

    localparam int HW = $clog2(RST_PULSE_CYCLES + 1) + 1;

    logic [HW-1:0] high_q;

    // Length of the current reset pulse so far.
    always_ff @(posedge clk) begin
        if (!rst_n || expire) high_q <= '0;
        else if (wd_reset_o)  high_q <= high_q + 1'b1;
        else                  high_q <= '0;
    end

    AST_PULSE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        wd_reset_o |-> (high_q < HW'(RST_PULSE_CYCLES)));  // R9
    AST_RESET_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wd_reset_o) |-> ($past(act_q) == ACT_RESET));  // R9
    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wd_irq_o) |-> ($past(act_q) == ACT_IRQ));  // R11
    AST_IRQ_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(OFS_CTRL) && bus_wdata == DATA_W'(RESTART_WORD) && en_q)
        |=> !wd_irq_o);  // R10
    AST_CTRL_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(OFS_CTRL)) |-> (bus_rdata == '0));  // R2
    AST_IDLE_NO_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> !expire);  // R8

endmodule

bind keyed_watchdog wdt_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RST_PULSE_CYCLES(RST_PULSE_CYCLES)
) u_wdt_checker (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wd_reset_o(wd_reset_o),
    .wd_irq_o(wd_irq_o), .en_q(en_q), .act_q(act_q), .expire(expire)
);

// File: tb/test_keyed_watchdog.sv
`timescale 1ns/1ps
module test_keyed_watchdog;

    localparam int HALF  = 4;
    localparam int PULSE = 3;
    localparam logic [7:0] A_CTRL = 8'h10;
    localparam logic [7:0] A_CFG  = 8'h14;
    localparam logic [7:0] A_MODE = 8'h18;
    localparam logic [31:0] KEY_WORD = 32'h0000_14AF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        wd_reset_o, wd_irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    keyed_watchdog #(.HALF_SEC_CYCLES(HALF), .RST_PULSE_CYCLES(PULSE)) i_keyed_watchdog (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .wd_reset_o(wd_reset_o), .wd_irq_o(wd_irq_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Enter and leave at a falling edge; the write lands on the rising edge between.
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = 32'h0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a; #1; d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(A_CTRL, v); chk("R1 ctrl", v, 0);
        rd(A_CFG, v);  chk("R1 cfg", v, 0);
        rd(A_MODE, v); chk("R1 mode", v, 0);
        chk("R1 outputs", {wd_reset_o, wd_irq_o}, 0);
    endtask

    task automatic t_readback();
        logic [31:0] v;
        wr(A_CFG, 32'hFFFF_FFFF);   rd(A_CFG, v);  chk("R2 cfg", v, 32'h3);
        wr(A_MODE, 32'hFFFF_FF70);  rd(A_MODE, v); chk("R2 mode", v, 32'h70);
        wr(A_CTRL, 32'h0000_1234);  rd(A_CTRL, v); chk("R2 ctrl", v, 0);
        wr(A_CFG, 0); wr(A_MODE, 0);
    endtask

    // Start with reset action, check expiry edge and pulse length.
    task automatic t_code(input logic [3:0] code, input int ticks, input string req);
        int t;
        t = ticks * HALF;
        wr(A_CFG, 32'h1);
        wr(A_MODE, {24'h0, code, 4'h1});
        idle(t - 1); chk({req, " before expiry"}, wd_reset_o, 0);
        idle(1);     chk({req, " at expiry"}, wd_reset_o, 1);
        idle(PULSE - 1); chk("R9 pulse last", wd_reset_o, 1);
        idle(1);         chk("R9 pulse end", wd_reset_o, 0);
        wr(A_MODE, 0); idle(PULSE);
    endtask

    task automatic t_restart();
        wr(A_CFG, 32'h1);
        wr(A_MODE, 32'h11);
        idle(5);
        wr(A_CTRL, KEY_WORD);
        idle(7); chk("R5 no early expiry", wd_reset_o, 0);
        idle(1); chk("R5 expiry after restart", wd_reset_o, 1);
        wr(A_MODE, 0); idle(PULSE);
    endtask

    task automatic t_badkey();
        wr(A_CFG, 32'h1);
        wr(A_MODE, 32'h11);
        idle(3);
        wr(A_CTRL, 32'h0000_14AE);
        wr(A_CTRL, 32'h0000_16AF);
        wr(A_CTRL, 32'h1000_14AF);
        idle(1); chk("R6 not yet", wd_reset_o, 0);
        idle(1); chk("R6 original expiry kept", wd_reset_o, 1);
        wr(A_MODE, 0); idle(PULSE);
    endtask

    task automatic t_reenable();
        wr(A_CFG, 32'h1);
        wr(A_MODE, 32'h21);
        idle(5);
        wr(A_MODE, 32'h51);
        idle(9); chk("R7 not yet", wd_reset_o, 0);
        idle(1); chk("R7 expiry undisturbed", wd_reset_o, 1);
        wr(A_MODE, 0); idle(PULSE);
    endtask

    task automatic t_stop();
        logic seen;
        logic [31:0] v;
        seen = 1'b0;
        wr(A_CFG, 32'h1);
        wr(A_MODE, 32'h11);
        idle(3);
        wr(A_MODE, 0);
        for (int i = 0; i < 20; i++) begin idle(1); seen |= wd_reset_o; end
        chk("R8 no expiry after stop", seen, 0);
        rd(A_MODE, v); chk("R8 mode reads stopped", v, 0);
        // A stop written on the expiry edge itself wins.
        wr(A_MODE, 32'h01);
        idle(HALF - 1);
        wr(A_MODE, 0);
        chk("R8 stop at expiry edge", wd_reset_o, 0);
        idle(PULSE);
    endtask

    task automatic t_irq();
        wr(A_CFG, 32'h2);
        wr(A_MODE, 32'h01);
        idle(HALF - 1); chk("R10 irq before", wd_irq_o, 0);
        idle(1);        chk("R10 irq set", wd_irq_o, 1);
        chk("R10 no reset with irq action", wd_reset_o, 0);
        idle(5);        chk("R10 irq held", wd_irq_o, 1);
        wr(A_CTRL, KEY_WORD); chk("R10 irq cleared by restart", wd_irq_o, 0);
        idle(HALF);     chk("R10 irq set again", wd_irq_o, 1);
        wr(A_MODE, 0);  chk("R10 irq cleared by stop", wd_irq_o, 0);
    endtask

    task automatic t_none(input logic [1:0] a, input string req);
        logic seen;
        seen = 1'b0;
        wr(A_CFG, {30'h0, a});
        wr(A_MODE, 32'h01);
        for (int i = 0; i < 12; i++) begin idle(1); seen |= wd_reset_o | wd_irq_o; end
        chk(req, seen, 0);
        wr(A_MODE, 0);
    endtask

    task automatic t_periodic();
        wr(A_CFG, 32'h1);
        wr(A_MODE, 32'h01);
        idle(HALF);     chk("R12 first expiry", wd_reset_o, 1);
        idle(PULSE);    chk("R12 gap", wd_reset_o, 0);
        idle(1);        chk("R12 second expiry", wd_reset_o, 1);
        wr(A_MODE, 0); idle(PULSE);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        t_reset();
        t_readback();
        t_code(4'h0, 1,  "R3 code0");
        t_code(4'h3, 6,  "R3 code3");
        t_code(4'h7, 16, "R3 code7");
        t_code(4'hA, 28, "R3 codeA");
        t_code(4'hB, 32, "R3 codeB");
        t_code(4'hC, 32, "R4 codeC");
        t_code(4'hF, 32, "R4 codeF");
        t_restart();
        t_badkey();
        t_reenable();
        t_stop();
        t_irq();
        t_none(2'b00, "R11 action 00 silent");
        t_none(2'b11, "R11 action 11 silent");
        t_periodic();
        finish_run();
    end

endmodule